// File: doc/BRIEF.md
# Six-Source Vectored Interrupt Controller

This block sits next to a small processor core and decides which of six interrupt sources to service. The sources are two external inputs, three timers and a serial port. Each source's request passes through its own enable bit and a global enable. Each source also has a one-bit priority that places it in the high or the low group. The controller shows the winning request to the core as a 16-bit vector address. The core takes the vector by raising an accept strobe at an instruction boundary.

The controller keeps two in-service bits, one for each priority level. A return strobe from the core clears whichever level is currently the innermost. When a vector is taken, a registered one-cycle acknowledge pulse follows. Alongside it, a one-hot clear strobe tells the flag owner which flag to drop. This happens only for the two simple timers and for external inputs configured as edge-triggered. The serial request and the third timer's request are each the OR of two flags. Software must clear those flags, so an uncleared request fires again after return.

Top module: `vic_top`

## Requirements
- R1: While rst_n is low, ack_o is 0, clr_o is 0 and in_svc_o is 00.
- R2: Source k (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2) presents vector address 0003h + 8*k on vec_o.
- R3: src_flag_i maps bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 serial receive, bit5 serial transmit, bit6 timer2 overflow, bit7 timer2 external. The serial request is bit4 OR bit5, and the timer2 request is bit6 OR bit7.
- R4: A source is pending only when enable_i bit 7 (global) and enable_i bit k are both 1.
- R5: prio_i bit k = 1 puts source k in the high group. A pending high request wins over any low request, whatever the source numbers.
- R6: Within one priority group, the lowest source number wins.
- R7: When irq_valid_o, accept_i and not reti_i all hold at a clock edge, ack_o is 1 for exactly the next cycle. At the same edge, the in-service bit of the taken level is set.
- R8: clr_o is one-hot together with ack_o. Bit 1 or 3 is raised for a timer0 or timer1 entry. Bit 0 or 2 is raised only if ext_edge_i bit 0 or 1 is set. Bits 4 and 5 are never raised.
- R9: With in_svc_o[1] (high active) set, no request is presented. With in_svc_o[0] (low active) set, only high requests are presented.
- R10: A reti_i pulse clears in_svc_o[1] if it is set, and otherwise clears in_svc_o[0]. A request still pending afterwards is presented again.
- R11: No request is presented in a cycle where ack_o is 1. accept_i is ignored in a cycle where reti_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag_i | input | 8 | Raw source flags, layout in R3 |
| enable_i | input | 8 | Per-source enables (bits 0-5), global enable (bit 7) |
| prio_i | input | 8 | Per-source priority (bits 0-5) |
| ext_edge_i | input | 2 | External input k is edge-triggered (auto-cleared) |
| accept_i | input | 1 | Core takes the presented vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_valid_o | output | 1 | A request is presented |
| vec_o | output | 16 | Vector address of the presented request |
| ack_o | output | 1 | One-cycle acknowledge after a vector is taken |
| clr_o | output | 6 | One-hot flag clear strobe, per source |
| in_svc_o | output | 2 | In-service levels: bit1 high, bit0 low |

## Verification
The checker watches several rules on every cycle: the acknowledge timing after a take, the clear strobe's one-hot shape and its exclusion of the serial and timer2 sources, masking by the global enable, blocking while a high handler runs, and the retire order of the in-service bits. Other behaviours appear only in the bench's scenarios. These are the actual vector values, the winner of each priority contest, the OR of the combined flags, and the fact that an uncleared request fires again after return.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC    = 6;
  localparam int NFLAG   = 8;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int VEC_W   = 16;
  localparam logic [VEC_W-1:0] VEC_BASE   = 16'h0003;
  localparam int               VEC_STRIDE = 8;
  localparam int GLOBAL_EN_BIT = 7;

  typedef logic [IDX_W-1:0] src_idx_t;

  function automatic logic [VEC_W-1:0] vec_of(input src_idx_t idx);
    return VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
  endfunction

  // Flag clear mask for an entry into source idx
  function automatic logic [NSRC-1:0] clr_of(input src_idx_t idx, input logic [1:0] edge_cfg);
    logic [NSRC-1:0] m;
    m = '0;
    case (idx)
      3'd0: m[0] = edge_cfg[0];
      3'd1: m[1] = 1'b1;
      3'd2: m[2] = edge_cfg[1];
      3'd3: m[3] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vic_pending.sv
module vic_pending
  import vic_pkg::*;
(
  input  logic [NFLAG-1:0] src_flag_i,
  input  logic [7:0]       enable_i,
  input  logic [7:0]       prio_i,
  output logic [NSRC-1:0]  pend_hi_o,
  output logic [NSRC-1:0]  pend_lo_o
);
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] pend;

  always_comb begin
    req[0] = src_flag_i[0];
    req[1] = src_flag_i[1];
    req[2] = src_flag_i[2];
    req[3] = src_flag_i[3];
    req[4] = src_flag_i[4] | src_flag_i[5];
    req[5] = src_flag_i[6] | src_flag_i[7];
  end

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_mask
      assign pend[k] = req[k] & enable_i[k] & enable_i[GLOBAL_EN_BIT];
    end
  endgenerate

  assign pend_hi_o = pend & prio_i[NSRC-1:0];
  assign pend_lo_o = pend & ~prio_i[NSRC-1:0];
endmodule

// File: rtl/vic_find_first.sv
module vic_find_first #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_state.sv
module vic_state
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            take_hi_i,
  input  logic [NSRC-1:0] take_clr_i,
  input  logic            reti_i,
  output logic            svc_hi_o,
  output logic            svc_lo_o,
  output logic            ack_o,
  output logic [NSRC-1:0] clr_o
);
  logic            svc_hi_q, svc_hi_d;
  logic            svc_lo_q, svc_lo_d;
  logic            ack_q, ack_d;
  logic [NSRC-1:0] clr_q, clr_d;

  always_comb begin
    svc_hi_d = svc_hi_q;
    svc_lo_d = svc_lo_q;
    if (take_i) begin
      if (take_hi_i) svc_hi_d = 1'b1;
      else           svc_lo_d = 1'b1;
    end else if (reti_i) begin
      if (svc_hi_q) svc_hi_d = 1'b0;
      else          svc_lo_d = 1'b0;
    end
    ack_d = take_i;
    clr_d = take_i ? take_clr_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi_q <= 1'b0;
      svc_lo_q <= 1'b0;
      ack_q    <= 1'b0;
      clr_q    <= '0;
    end else begin
      svc_hi_q <= svc_hi_d;
      svc_lo_q <= svc_lo_d;
      ack_q    <= ack_d;
      clr_q    <= clr_d;
    end
  end

  assign svc_hi_o = svc_hi_q;
  assign svc_lo_o = svc_lo_q;
  assign ack_o    = ack_q;
  assign clr_o    = clr_q;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  src_flag_i,
  input  logic [7:0]  enable_i,
  input  logic [7:0]  prio_i,
  input  logic [1:0]  ext_edge_i,
  input  logic        accept_i,
  input  logic        reti_i,
  output logic        irq_valid_o,
  output logic [15:0] vec_o,
  output logic        ack_o,
  output logic [5:0]  clr_o,
  output logic [1:0]  in_svc_o
);
  logic [NSRC-1:0] pend_hi, pend_lo;
  logic            hi_found, lo_found;
  src_idx_t        hi_idx, lo_idx;
  logic            svc_hi, svc_lo;
  logic            sel_valid, sel_hi;
  src_idx_t        sel_idx;
  logic            take;

  vic_pending u_pend (
    .src_flag_i (src_flag_i),
    .enable_i   (enable_i),
    .prio_i     (prio_i),
    .pend_hi_o  (pend_hi),
    .pend_lo_o  (pend_lo)
  );

  vic_find_first #(.N(NSRC)) u_ff_hi (
    .mask_i  (pend_hi),
    .found_o (hi_found),
    .idx_o   (hi_idx)
  );

  vic_find_first #(.N(NSRC)) u_ff_lo (
    .mask_i  (pend_lo),
    .found_o (lo_found),
    .idx_o   (lo_idx)
  );

  // Level gating: high needs no high handler active; low needs none active.
  always_comb begin
    sel_valid = 1'b0;
    sel_hi    = 1'b0;
    sel_idx   = '0;
    if (hi_found && !svc_hi) begin
      sel_valid = 1'b1;
      sel_hi    = 1'b1;
      sel_idx   = hi_idx;
    end else if (lo_found && !svc_hi && !svc_lo) begin
      sel_valid = 1'b1;
      sel_idx   = lo_idx;
    end
  end

  assign irq_valid_o = sel_valid & ~ack_o;
  assign vec_o       = vec_of(sel_idx);
  assign take        = irq_valid_o & accept_i & ~reti_i;

  vic_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .take_hi_i  (sel_hi),
    .take_clr_i (clr_of(sel_idx, ext_edge_i)),
    .reti_i     (reti_i),
    .svc_hi_o   (svc_hi),
    .svc_lo_o   (svc_lo),
    .ack_o      (ack_o),
    .clr_o      (clr_o)
  );

  assign in_svc_o = {svc_hi, svc_lo};
endmodule

// File: rtl/vic_chk.sv
module vic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  enable_i,
  input logic        accept_i,
  input logic        reti_i,
  input logic        irq_valid_o,
  input logic        ack_o,
  input logic [5:0]  clr_o,
  input logic [1:0]  in_svc_o
);
  // R7
  ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && accept_i && !reti_i) |=> ack_o);
  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  // R11
  no_valid_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !irq_valid_o);
  // R8
  clr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o) && clr_o[5:4] == 2'b00);
  // R8
  clr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != 6'd0) |-> ack_o);
  // R4
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i[7] |-> !irq_valid_o);
  // R9
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_o[1] |-> !irq_valid_o);
  // R10
  reti_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && in_svc_o[1]) |=> !in_svc_o[1]);
endmodule

bind vic_top vic_chk u_vic_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .accept_i    (accept_i),
  .reti_i      (reti_i),
  .irq_valid_o (irq_valid_o),
  .ack_o       (ack_o),
  .clr_o       (clr_o),
  .in_svc_o    (in_svc_o)
);

// File: tb/vic_top_tb.sv
module vic_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  src_flag_i;
  logic [7:0]  enable_i;
  logic [7:0]  prio_i;
  logic [1:0]  ext_edge_i;
  logic        accept_i;
  logic        reti_i;
  logic        irq_valid_o;
  logic [15:0] vec_o;
  logic        ack_o;
  logic [5:0]  clr_o;
  logic [1:0]  in_svc_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vic_top dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {flags, enable, prio, exp_valid, exp_vec}
  localparam int NV = 10;
  localparam logic [40:0] TBL [NV] = '{
    {8'h08, 8'h88, 8'h00, 1'b1, 16'h001B},  // R2 R4 timer1 alone
    {8'h01, 8'h01, 8'h00, 1'b0, 16'h0000},  // R4 no global enable
    {8'hFF, 8'hBF, 8'h00, 1'b1, 16'h0003},  // R6 all low, ext0 wins
    {8'hFF, 8'hBF, 8'h20, 1'b1, 16'h002B},  // R5 timer2 high wins
    {8'h20, 8'h90, 8'h00, 1'b1, 16'h0023},  // R3 transmit flag
    {8'h10, 8'h90, 8'h00, 1'b1, 16'h0023},  // R3 receive flag
    {8'h80, 8'hA0, 8'h00, 1'b1, 16'h002B},  // R3 timer2 external flag
    {8'h40, 8'h80, 8'h00, 1'b0, 16'h0000},  // R4 timer2 enable bit off
    {8'h0C, 8'h8C, 8'h08, 1'b1, 16'h001B},  // R5 high timer1 beats ext1
    {8'h0A, 8'h8A, 8'h0A, 1'b1, 16'h000B}   // R6 both high, timer0 wins
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src_flag_i = 8'h00; enable_i = 8'h00; prio_i = 8'h00;
    ext_edge_i = 2'b00; accept_i = 1'b0; reti_i = 1'b0;
    #35;
    chk(ack_o == 0 && clr_o == 0 && in_svc_o == 0, "R1", {ack_o, clr_o, in_svc_o}, 0);
    tick();
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      src_flag_i = TBL[i][40:33];
      enable_i   = TBL[i][32:25];
      prio_i     = TBL[i][24:17];
      #1;
      chk(irq_valid_o == TBL[i][16], "R2-table valid", irq_valid_o, TBL[i][16]);
      if (TBL[i][16])
        chk(vec_o == TBL[i][15:0], "R2-table vector", vec_o, TBL[i][15:0]);
      tick();
    end

    // R7 R8: take timer0, low level
    src_flag_i = 8'h02; enable_i = 8'h82; prio_i = 8'h00; accept_i = 1'b1;
    #1; chk(irq_valid_o && vec_o == 16'h000B, "R2", vec_o, 16'h000B);
    tick(); accept_i = 1'b0; #1;
    chk(ack_o == 1, "R7 ack", ack_o, 1);
    chk(clr_o == 6'b000010, "R8 timer0 clear", clr_o, 6'b000010);
    chk(in_svc_o == 2'b01, "R7 level", in_svc_o, 2'b01);
    chk(irq_valid_o == 0, "R11", irq_valid_o, 0);
    tick(); #1;
    chk(ack_o == 0, "R7 single", ack_o, 0);
    chk(irq_valid_o == 0, "R9 low blocks low", irq_valid_o, 0);
    src_flag_i = 8'h00; reti_i = 1'b1;
    tick(); reti_i = 1'b0; #1;
    chk(in_svc_o == 2'b00, "R10 reti low", in_svc_o, 2'b00);

    // R8 R10: ext0 level-type, no clear, retriggers
    src_flag_i = 8'h01; enable_i = 8'h81; accept_i = 1'b1;
    tick(); accept_i = 1'b0; #1;
    chk(ack_o == 1 && clr_o == 0, "R8 ext0 level no clear", clr_o, 0);
    tick(); reti_i = 1'b1;
    tick(); reti_i = 1'b0; #1;
    chk(irq_valid_o && vec_o == 16'h0003, "R10 retrigger ext0", vec_o, 16'h0003);
    ext_edge_i = 2'b01; accept_i = 1'b1;
    tick(); accept_i = 1'b0; #1;
    chk(clr_o == 6'b000001, "R8 ext0 edge clear", clr_o, 6'b000001);
    src_flag_i = 8'h00;
    tick(); reti_i = 1'b1;
    tick(); reti_i = 1'b0;

    // R8 R10: serial never auto-cleared
    src_flag_i = 8'h10; enable_i = 8'h90; accept_i = 1'b1;
    tick(); accept_i = 1'b0; #1;
    chk(ack_o == 1 && clr_o == 0, "R8 serial no clear", clr_o, 0);
    chk(in_svc_o == 2'b01, "R7 serial level", in_svc_o, 2'b01);
    tick(); reti_i = 1'b1;
    tick(); reti_i = 1'b0; #1;
    chk(irq_valid_o && vec_o == 16'h0023, "R10 retrigger serial", vec_o, 16'h0023);
    src_flag_i = 8'h00;
    tick();

    // R9 R10: preemption and nesting
    src_flag_i = 8'h02; enable_i = 8'h8E; prio_i = 8'h0C; accept_i = 1'b1;
    tick(); accept_i = 1'b0; #1;
    chk(in_svc_o == 2'b01, "R7 low entry", in_svc_o, 2'b01);
    tick();
    src_flag_i = 8'h06; #1;
    chk(irq_valid_o && vec_o == 16'h0013, "R9 high preempts low", vec_o, 16'h0013);
    accept_i = 1'b1;
    tick(); accept_i = 1'b0; #1;
    chk(in_svc_o == 2'b11, "R9 nested", in_svc_o, 2'b11);
    chk(clr_o == 6'b000000, "R8 ext1 level no clear", clr_o, 0);
    tick();
    src_flag_i = 8'h0E; #1;
    chk(irq_valid_o == 0, "R9 high blocks high", irq_valid_o, 0);
    src_flag_i = 8'h00; reti_i = 1'b1;
    tick(); #1;
    chk(in_svc_o == 2'b01, "R10 high retired first", in_svc_o, 2'b01);
    tick(); reti_i = 1'b0; #1;
    chk(in_svc_o == 2'b00, "R10 low retired", in_svc_o, 2'b00);

    // R11: accept with reti ignored
    src_flag_i = 8'h02; enable_i = 8'h82; prio_i = 8'h00;
    accept_i = 1'b1; reti_i = 1'b1;
    tick(); accept_i = 1'b0; reti_i = 1'b0; #1;
    chk(ack_o == 0 && in_svc_o == 2'b00, "R11 accept during reti", {ack_o, in_svc_o}, 0);

    // R1: reset mid-service
    accept_i = 1'b1;
    tick(); accept_i = 1'b0; rst_n = 1'b0; #1;
    chk(ack_o == 0 && clr_o == 0 && in_svc_o == 0, "R1 reset clears", {ack_o, clr_o, in_svc_o}, 0);
    tick();
    finish_run();
  end
endmodule